// File: doc/BRIEF.md
# Halfword-to-Line Memory Bridge

This block lets a requester that speaks a simple 16-bit static-RAM-style protocol use the 128-bit user interface of an external SDRAM controller. The RAM side has an address, an active-low chip enable, an active-low write enable, separate active-low enables for the upper and lower byte, and a busy output. Every access is turned into one command on an aligned 16-byte line. On a write, the halfword is placed in its lane and every other byte is masked. On a read, the addressed lane is extracted from the returned line.

The bridge accepts nothing until the controller reports that calibration has finished. It then runs the controller's command handshake and, for writes, the write-data handshake. It holds busy high until the write beat is taken or the read line has been captured. Because only the addressed bytes are unmasked, halfwords that share a line never overwrite one another.

Top module: `halfword_line_bridge`

## Requirements
- R1: After reset, busy, the command enable and the write-data strobe are all low.
- R2: While the calibration-done input is low, a low chip enable starts no access: the command enable and busy stay low.
- R3: The command address equals the captured RAM address with its four least-significant bits cleared. The command code is 000 for a write and 001 for a read.
- R4: The command enable stays high in every cycle until the cycle in which the controller's ready input is sampled high. It is low in the cycle that follows.
- R5: On a write, the halfword appears in lane L of the write data (bits 16L+15 down to 16L), where L is RAM address bits [3:1].
- R6: Write-mask bits are 1 for "keep". Bit 2L is 0 only if the lower byte is enabled, and bit 2L+1 is 0 only if the upper byte is enabled. All other bits are 1.
- R7: After the command is accepted, the write strobe and the end flag are high together. They are held until write-data-ready is sampled high, and that edge completes the write.
- R8: A read completes only on an edge where read-valid and read-end are both high. The RAM read data then holds lane L of that line. A beat with only one of the two flags high is ignored.
- R9: A read with only the upper byte enabled returns that byte on both halves of the 16-bit output.
- R10: Busy is high from the cycle after an access is accepted until the completing edge. The command address stays stable throughout, and a chip-enable pulse while busy starts no further access.
- R11: Writes to different lanes of the same line leave each other's bytes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calDone | input | 1 | Controller calibration finished |
| ramAddr | input | 27 | RAM-side byte address |
| ramCeN | input | 1 | Access request, active low |
| ramWeN | input | 1 | Write when low, read when high |
| ramUbN | input | 1 | Upper byte enable, active low |
| ramLbN | input | 1 | Lower byte enable, active low |
| ramWrData | input | 16 | Write halfword |
| ramRdData | output | 16 | Read halfword, valid once busy drops after a read |
| ramBusy | output | 1 | Access in progress |
| uiAddr | output | 27 | Line address to the controller |
| uiCmd | output | 3 | Command code |
| uiEn | output | 1 | Command valid |
| uiRdy | input | 1 | Controller accepts the command |
| wdfData | output | 128 | Write line data |
| wdfMask | output | 16 | Per-byte keep mask |
| wdfWren | output | 1 | Write data valid |
| wdfEnd | output | 1 | Last write beat |
| wdfRdy | input | 1 | Controller accepts write data |
| rdData | input | 128 | Returned read line |
| rdValid | input | 1 | Read data valid |
| rdEnd | input | 1 | Last read beat |

## Verification
The bench pairs a byte-masked line memory, driven by the bridge's own mask, with a byte shadow that is updated only from the RAM-side intent. Any lane, mask or extraction error therefore shows up as a readback mismatch. Directed writes to lanes 0 and 7 of one line, followed by reads of both, separate correct masking from whole-line overwrites. Upper-only and lower-only accesses separate the byte-enable decoding from the lane selection. Random stalls on both ready inputs, lone valid or end flags on reads, and chip-enable pulses while busy show whether the sequencer waits for the exact completion condition and ignores everything else.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WDATA, ST_RWAIT} hlbState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capReq;   // latch a new RAM-side request
    logic capRead;  // latch the addressed lane of the returned line
  } hlbStrobe_t;

  localparam logic [2:0] CMD_WRITE = 3'b000;
  localparam logic [2:0] CMD_READ  = 3'b001;
endpackage

// File: rtl/hlb_ctrl.sv
module hlb_ctrl
  import hlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       calDone,
  input  logic       ramCeN,
  input  logic       isWrite,
  input  logic       uiRdy,
  input  logic       wdfRdy,
  input  logic       rdValid,
  input  logic       rdEnd,
  output hlbStrobe_t strobe,
  output logic       uiEn,
  output logic       wdfWren,
  output logic       wdfEnd,
  output logic       busy
);
  hlbState_e state, stateNext;

  always_comb begin
    strobe.capReq  = (state == ST_IDLE) && calDone && !ramCeN;
    strobe.capRead = (state == ST_RWAIT) && rdValid && rdEnd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.capReq) stateNext = ST_CMD;
      ST_CMD:   if (uiRdy) stateNext = isWrite ? ST_WDATA : ST_RWAIT;
      ST_WDATA: if (wdfRdy) stateNext = ST_IDLE;
      ST_RWAIT: if (strobe.capRead) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign uiEn    = (state == ST_CMD);
  assign wdfWren = (state == ST_WDATA);
  assign wdfEnd  = (state == ST_WDATA);
  assign busy    = (state != ST_IDLE);

  AST_NO_CMD_UNCAL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !calDone) |=> !uiEn); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (uiEn && !uiRdy) |=> uiEn); // R4
  AST_EN_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (uiEn && uiRdy) |=> !uiEn); // R4
  AST_WBEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wdfWren && !wdfRdy) |=> (wdfWren && wdfEnd)); // R7
  AST_WBEAT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (wdfWren && wdfRdy) |=> !busy); // R7
endmodule

// File: rtl/hlb_dp.sv
module hlb_dp
  import hlb_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  hlbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic              ramWeN,
  input  logic              ramUbN,
  input  logic              ramLbN,
  input  logic [15:0]       ramWrData,
  input  logic [LINE_W-1:0] lineIn,
  output logic              isWrite,
  output logic [ADDR_W-1:0] uiAddr,
  output logic [2:0]        uiCmd,
  output logic [LINE_W-1:0] wdfData,
  output logic [LINE_W/8-1:0] wdfMask,
  output logic [15:0]       ramRdData
);
  localparam int HALF_W = 16;
  localparam int LANES  = LINE_W / HALF_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int MASK_W = LINE_W / 8;
  localparam int OFFS_W = $clog2(MASK_W);

  logic [ADDR_W-1:0] addrQ;
  logic              weQ, ubQ, lbQ;
  logic [HALF_W-1:0] wdQ;
  logic [LANE_W-1:0] laneSel;
  logic [HALF_W-1:0] laneData, rdPick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      weQ   <= 1'b0;
      ubQ   <= 1'b0;
      lbQ   <= 1'b0;
      wdQ   <= '0;
    end else if (strobe.capReq) begin
      addrQ <= ramAddr;
      weQ   <= !ramWeN;
      ubQ   <= !ramUbN;
      lbQ   <= !ramLbN;
      wdQ   <= ramWrData;
    end
  end

  assign laneSel = addrQ[OFFS_W-1:1];
  assign isWrite = weQ;
  assign uiCmd   = weQ ? CMD_WRITE : CMD_READ;
  assign uiAddr  = {addrQ[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wdfData[l*HALF_W +: HALF_W] = wdQ;
    assign wdfMask[2*l]   = !((laneSel == LANE_W'(l)) && lbQ);
    assign wdfMask[2*l+1] = !((laneSel == LANE_W'(l)) && ubQ);
  end

  assign laneData = lineIn[laneSel*HALF_W +: HALF_W];
  assign rdPick   = (ubQ && !lbQ) ? {laneData[15:8], laneData[15:8]} : laneData;

  always_ff @(posedge clk) begin
    if (!rstN)               ramRdData <= '0;
    else if (strobe.capRead) ramRdData <= rdPick;
  end

  AST_CAP_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capReq |=> (uiAddr[OFFS_W-1:0] == '0 && isWrite == !$past(ramWeN))); // R3
endmodule

// File: rtl/halfword_line_bridge.sv
module halfword_line_bridge
  import hlb_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int LINE_W = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calDone,
  input  logic [ADDR_W-1:0]   ramAddr,
  input  logic                ramCeN,
  input  logic                ramWeN,
  input  logic                ramUbN,
  input  logic                ramLbN,
  input  logic [15:0]         ramWrData,
  output logic [15:0]         ramRdData,
  output logic                ramBusy,
  output logic [ADDR_W-1:0]   uiAddr,
  output logic [2:0]          uiCmd,
  output logic                uiEn,
  input  logic                uiRdy,
  output logic [LINE_W-1:0]   wdfData,
  output logic [LINE_W/8-1:0] wdfMask,
  output logic                wdfWren,
  output logic                wdfEnd,
  input  logic                wdfRdy,
  input  logic [LINE_W-1:0]   rdData,
  input  logic                rdValid,
  input  logic                rdEnd
);
  hlbStrobe_t strobe;
  logic       isWrite;

  hlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .calDone(calDone), .ramCeN(ramCeN),
    .isWrite(isWrite), .uiRdy(uiRdy), .wdfRdy(wdfRdy), .rdValid(rdValid),
    .rdEnd(rdEnd), .strobe(strobe), .uiEn(uiEn), .wdfWren(wdfWren),
    .wdfEnd(wdfEnd), .busy(ramBusy)
  );

  hlb_dp #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramAddr(ramAddr),
    .ramWeN(ramWeN), .ramUbN(ramUbN), .ramLbN(ramLbN), .ramWrData(ramWrData),
    .lineIn(rdData), .isWrite(isWrite), .uiAddr(uiAddr), .uiCmd(uiCmd),
    .wdfData(wdfData), .wdfMask(wdfMask), .ramRdData(ramRdData)
  );

  AST_MASK_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    wdfWren |-> ($countones(~wdfMask) <= 2)); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ramBusy ##1 ramBusy) |-> $stable(uiAddr)); // R10
endmodule

// File: tb/tb_halfword_line_bridge.sv
module tb_halfword_line_bridge;
  logic         clk = 1'b0;
  logic         rstN, calDone, ramCeN, ramWeN, ramUbN, ramLbN;
  logic [26:0]  ramAddr;
  logic [15:0]  ramWrData, ramRdData;
  logic         ramBusy, uiEn, uiRdy, wdfWren, wdfEnd, wdfRdy, rdValid, rdEnd;
  logic [26:0]  uiAddr;
  logic [2:0]   uiCmd;
  logic [127:0] wdfData, rdData;
  logic [15:0]  wdfMask;

  logic [127:0] mem [16];
  logic [7:0]   shadow [16][16];
  int checks = 0;
  int fails  = 0;

  always #4 clk = !clk;

  halfword_line_bridge dut (
    .clk(clk), .rstN(rstN), .calDone(calDone), .ramAddr(ramAddr),
    .ramCeN(ramCeN), .ramWeN(ramWeN), .ramUbN(ramUbN), .ramLbN(ramLbN),
    .ramWrData(ramWrData), .ramRdData(ramRdData), .ramBusy(ramBusy),
    .uiAddr(uiAddr), .uiCmd(uiCmd), .uiEn(uiEn), .uiRdy(uiRdy),
    .wdfData(wdfData), .wdfMask(wdfMask), .wdfWren(wdfWren), .wdfEnd(wdfEnd),
    .wdfRdy(wdfRdy), .rdData(rdData), .rdValid(rdValid), .rdEnd(rdEnd)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expMask(input int lane, input bit ub, input bit lb);
    logic [15:0] m = '1;
    if (lb) m[2*lane]   = 1'b0;
    if (ub) m[2*lane+1] = 1'b0;
    return m;
  endfunction

  task automatic access(input bit we, input logic [26:0] a, input bit ub, input bit lb,
                        input logic [15:0] wd, input bit intrude);
    int idx  = int'(a[7:4]);
    int lane = int'(a[3:1]);
    int stall;
    logic [26:0] expAddr = {a[26:4], 4'b0};
    logic [15:0] expRd;
    ramAddr = a; ramWeN = !we; ramUbN = !ub; ramLbN = !lb; ramWrData = wd; ramCeN = 1'b0;
    @(negedge clk);
    ramCeN = 1'b1; ramAddr = 27'($urandom); ramWrData = 16'($urandom);
    chk(ramBusy == 1'b1, "R10 busy after accept", 128'(ramBusy), 128'(1));
    chk(uiAddr == expAddr, "R3 line address", 128'(uiAddr), 128'(expAddr));
    chk(uiCmd == (we ? 3'b000 : 3'b001), "R3 command code", 128'(uiCmd), 128'(we ? 0 : 1));
    stall = $urandom % 4;
    for (int i = 0; i <= stall; i++) begin
      chk(uiEn == 1'b1, "R4 enable held", 128'(uiEn), 128'(1));
      if (intrude && i == 0) begin
        ramCeN = 1'b0; ramAddr = a ^ 27'h1230;
      end
      uiRdy = (i == stall);
      @(negedge clk);
      ramCeN = 1'b1;
      chk(uiAddr == expAddr, "R10 address stable", 128'(uiAddr), 128'(expAddr));
    end
    uiRdy = 1'b0;
    chk(uiEn == 1'b0, "R4 enable dropped", 128'(uiEn), 128'(0));
    if (we) begin
      stall = $urandom % 4;
      for (int i = 0; i <= stall; i++) begin
        chk(wdfWren && wdfEnd, "R7 strobe and end", {wdfWren, wdfEnd}, 2'b11);
        chk(wdfData[16*lane +: 16] == wd, "R5 lane data", wdfData[16*lane +: 16], wd);
        chk(wdfMask == expMask(lane, ub, lb), "R6 mask", wdfMask, expMask(lane, ub, lb));
        wdfRdy = (i == stall);
        if (i == stall) begin
          for (int b = 0; b < 16; b++)
            if (!wdfMask[b]) mem[idx][8*b +: 8] = wdfData[8*b +: 8];
          if (lb) shadow[idx][2*lane]   = wd[7:0];
          if (ub) shadow[idx][2*lane+1] = wd[15:8];
        end
        @(negedge clk);
      end
      wdfRdy = 1'b0;
      chk(wdfWren == 1'b0, "R7 beat taken", 128'(wdfWren), 128'(0));
    end else begin
      stall = $urandom % 4;
      for (int i = 0; i < stall; i++) begin
        rdData  = {$urandom, $urandom, $urandom, $urandom};
        rdValid = (i == 0);
        rdEnd   = (i == 1);
        @(negedge clk);
        chk(ramBusy == 1'b1, "R8 lone flag ignored", 128'(ramBusy), 128'(1));
      end
      rdData = mem[idx]; rdValid = 1'b1; rdEnd = 1'b1;
      @(negedge clk);
      rdValid = 1'b0; rdEnd = 1'b0; rdData = {$urandom, $urandom, $urandom, $urandom};
      expRd = (ub && !lb) ? {shadow[idx][2*lane+1], shadow[idx][2*lane+1]}
                          : {shadow[idx][2*lane+1], shadow[idx][2*lane]};
      chk(ramRdData == expRd, (ub && !lb) ? "R9 upper byte doubled" : "R8 R11 read lane",
          128'(ramRdData), 128'(expRd));
    end
    chk(ramBusy == 1'b0, "R10 busy released", 128'(ramBusy), 128'(0));
    @(negedge clk);
    chk(uiEn == 1'b0 && ramBusy == 1'b0, "R10 no extra access", {uiEn, ramBusy}, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        shadow[i][j] = 8'(i * 16 + j) ^ 8'h5A;
        mem[i][8*j +: 8] = shadow[i][j];
      end
    rstN = 1'b0; calDone = 1'b0; ramCeN = 1'b1; ramWeN = 1'b1; ramUbN = 1'b0; ramLbN = 1'b0;
    ramAddr = '0; ramWrData = '0; uiRdy = 1'b0; wdfRdy = 1'b0; rdValid = 1'b0; rdEnd = 1'b0;
    rdData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ramBusy && !uiEn && !wdfWren, "R1 reset state", {ramBusy, uiEn, wdfWren}, 0);
    ramCeN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!uiEn && !ramBusy, "R2 wait for calibration", {uiEn, ramBusy}, 0);
    end
    ramCeN = 1'b1; calDone = 1'b1;
    @(negedge clk);

    // R11: two lanes of one line, then partial-byte writes and reads
    access(1'b1, 27'h0000030, 1'b1, 1'b1, 16'hA1B2, 1'b0);
    access(1'b1, 27'h000003E, 1'b1, 1'b1, 16'hC3D4, 1'b1);
    access(1'b1, 27'h0000036, 1'b0, 1'b1, 16'h77EE, 1'b0);
    access(1'b1, 27'h0000038, 1'b1, 1'b0, 16'h9911, 1'b0);
    access(1'b0, 27'h0000030, 1'b1, 1'b1, 16'h0, 1'b0);
    access(1'b0, 27'h000003E, 1'b1, 1'b1, 16'h0, 1'b0);
    access(1'b0, 27'h000003E, 1'b1, 1'b0, 16'h0, 1'b1);
    access(1'b0, 27'h0000036, 1'b0, 1'b1, 16'h0, 1'b0);
    access(1'b0, 27'h0000038, 1'b1, 1'b1, 16'h0, 1'b0);

    for (int n = 0; n < 120; n++) begin
      int sel = $urandom % 4;
      bit ub = (sel != 1);
      bit lb = (sel != 2);
      access(1'($urandom), 27'($urandom), ub, lb, 16'($urandom), 1'($urandom));
    end
    summary();
    $finish;
  end
endmodule